// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines, latches them into a pending register and filters them through a per-line mask. It then picks the most urgent one, with line 0 as the highest priority, and raises a single interrupt output toward the processor. When the processor acknowledges, the controller returns an 8-bit vector. The upper bits of that vector come from a programmed base and the lower three bits hold the winning line number. The controller also marks that line as in service, so that lines of equal or lower priority stay blocked until software signals end-of-interrupt.

Software reaches the controller through a two-address register window selected by `a0_i`. Address 0 is the command port and address 1 is the data port. A start command on the command port opens a three-word setup sequence on the data port, and that command also selects edge or level triggering. The first setup word carries the vector base. Outside setup, the data port holds the mask. Command-port writes also cover end-of-interrupt and the choice of which internal register the command port reads back. Reads have no side effects.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the interrupt output and vector-valid are low. The mask, pending and in-service registers are zero, the command-port readback shows the pending register, the vector base is zero and edge triggering is selected.
- R2: A command-port write with bit 4 set starts setup. Bit 3 of that write selects level (1) or edge (0) triggering. The same write clears the mask, pending and in-service registers and sets readback to the pending register. The next three data-port writes are setup words. The first sets the vector base from bits 7:3. The second and third change nothing visible, and the mask stays zero.
- R3: Outside setup, a data-port write loads the mask and a data-port read returns it. A masked line never raises the interrupt output and never wins an acknowledge. Masking a higher-priority line does not stop a lower-priority unmasked line from being served.
- R4: In edge mode a pending bit sets on a rising edge of its line and clears whenever the line is low. A line held high does not request again after it has been acknowledged and ended.
- R5: In level mode a pending bit follows the level of its line. A line still high after end-of-interrupt requests again.
- R6: Priority is fixed with line 0 highest. The interrupt output is high exactly when the lowest-numbered unmasked pending line has a lower number than every in-service line.
- R7: `inta_i` is a one-cycle pulse. In the following cycle `vector_valid_o` is high for one cycle and `vector_o` equals {base, line number} for the winning line. The winner's pending bit clears and its in-service bit sets.
- R8: An acknowledge that arrives while the interrupt output is low returns {base, 3'b111} and leaves the in-service register unchanged.
- R9: A command-port write with bits 4:3 = 00 and bits 7:5 = 001 clears the lowest-numbered set in-service bit. Other codes in bits 7:5 with bits 4:3 = 00 have no effect.
- R10: A command-port write with bits 4:3 = 01 and bits 1:0 = 10 selects the pending register for command-port reads, and bits 1:0 = 11 selects the in-service register. With bit 1 clear the selection is unchanged. The selection persists across any number of reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Register window select |
| wr_i | input | 1 | Write strobe, qualified by `cs_i` |
| a0_i | input | 1 | Port select: 0 command, 1 data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the port addressed by `a0_i` |
| irq_i | input | 8 | Request lines, bit n is line n |
| inta_i | input | 1 | Acknowledge pulse from the processor |
| intr_o | output | 1 | Interrupt request to the processor |
| vector_o | output | 8 | Vector returned for the last acknowledge |
| vector_valid_o | output | 1 | High in the cycle after an acknowledge |

## Verification
The in-service assertions assume that an acknowledge never shares a cycle with an end-of-interrupt or setup command, and that `inta_i` lasts a single cycle. The stimulus holds to this by issuing at most one register write or one acknowledge per clock. Request lines may toggle in any cycle, including the cycle of an acknowledge. Random phases in both trigger modes mix line toggles, acknowledges, end-of-interrupt commands, mask writes and readback selection. Directed sequences cover blocked nesting, spurious acknowledges and re-requests of held lines.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [1:0] {
        INIT_NONE = 2'd0,
        INIT_W1   = 2'd1,
        INIT_W2   = 2'd2,
        INIT_W3   = 2'd3
    } init_st_e;

    // command decode bit positions
    localparam int unsigned START_BIT    = 4;
    localparam int unsigned LEVEL_BIT    = 3;
    localparam int unsigned SEL_CMD_BIT  = 3;
    localparam int unsigned RDSEL_EN_BIT = 1;
    localparam int unsigned RDSEL_BIT    = 0;
    localparam int unsigned EOI_LSB      = 5;
    localparam logic [2:0]  EOI_NONSPEC  = 3'b001;
endpackage

// File: rtl/pic_first_set.sv
module pic_first_set #(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic [N-1:0]     vec_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    // lowest set index wins
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_i,
    input  logic         level_i,
    input  logic         clear_i,
    input  logic [N-1:0] ack_clr_i,
    output logic [N-1:0] irr_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] irr;
    } lat_t;

    lat_t l_q, l_d;
    logic [N-1:0] held;

    for (genvar g = 0; g < N; g++) begin : g_line
        assign held[g] = level_i ? irq_i[g]
                       : ((l_q.irr[g] | (irq_i[g] & ~l_q.prev[g])) & irq_i[g]);
    end

    always_comb begin
        l_d      = l_q;
        l_d.prev = irq_i;
        l_d.irr  = clear_i ? '0 : (held & ~ack_clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign irr_o = l_q.irr;

    // R4 / R5: a line that is low never leaves its pending bit set
    p_low_line_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((l_q.irr & ~$past(irq_i)) == '0));

    // R7: acknowledge clears at most one line
    p_ack_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_clr_i));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int unsigned N_IRQ  = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              wr_i,
    input  logic              a0_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [N_IRQ-1:0]  irq_i,
    input  logic              inta_i,
    output logic              intr_o,
    output logic [DATA_W-1:0] vector_o,
    output logic              vector_valid_o
);
    localparam int unsigned IDX_W  = $clog2(N_IRQ);
    localparam int unsigned BASE_W = DATA_W - IDX_W;

    typedef struct packed {
        init_st_e          init_st;
        logic              level;
        logic              sel_isr;
        logic [N_IRQ-1:0]  mask;
        logic [BASE_W-1:0] base;
        logic [N_IRQ-1:0]  isr;
        logic [DATA_W-1:0] vec;
        logic              vec_vld;
    } ctl_t;

    ctl_t c_q, c_d;

    logic             cmd_wr, dat_wr, is_start, is_sel, is_eoi;
    logic [N_IRQ-1:0] irr, pend, ack_clr;
    logic             pend_any, isr_any, grant;
    logic [IDX_W-1:0] pend_idx, isr_idx;

    assign cmd_wr   = cs_i & wr_i & ~a0_i;
    assign dat_wr   = cs_i & wr_i & a0_i;
    assign is_start = cmd_wr & wdata_i[START_BIT];
    assign is_sel   = cmd_wr & ~wdata_i[START_BIT] & wdata_i[SEL_CMD_BIT];
    assign is_eoi   = cmd_wr & ~wdata_i[START_BIT] & ~wdata_i[SEL_CMD_BIT]
                    & (wdata_i[EOI_LSB +: 3] == EOI_NONSPEC);

    pic_req_latch #(.N(N_IRQ)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_i     (irq_i),
        .level_i   (c_q.level),
        .clear_i   (is_start),
        .ack_clr_i (ack_clr),
        .irr_o     (irr)
    );

    assign pend = irr & ~c_q.mask;

    pic_first_set #(.N(N_IRQ), .IDX_W(IDX_W)) u_pend_enc (
        .vec_i   (pend),
        .found_o (pend_any),
        .idx_o   (pend_idx)
    );

    pic_first_set #(.N(N_IRQ), .IDX_W(IDX_W)) u_isr_enc (
        .vec_i   (c_q.isr),
        .found_o (isr_any),
        .idx_o   (isr_idx)
    );

    assign intr_o  = pend_any && (!isr_any || (pend_idx < isr_idx));
    assign grant   = inta_i & intr_o;
    assign ack_clr = grant ? (N_IRQ'(1) << pend_idx) : '0;

    always_comb begin
        c_d         = c_q;
        c_d.vec_vld = inta_i;
        if (inta_i) begin
            c_d.vec = {c_q.base, (grant ? pend_idx : {IDX_W{1'b1}})};
        end
        if (is_eoi && isr_any) c_d.isr[isr_idx] = 1'b0;
        if (grant)             c_d.isr[pend_idx] = 1'b1;
        if (is_sel && wdata_i[RDSEL_EN_BIT]) c_d.sel_isr = wdata_i[RDSEL_BIT];
        if (dat_wr) begin
            case (c_q.init_st)
                INIT_NONE: c_d.mask = wdata_i[N_IRQ-1:0];
                INIT_W1: begin
                    c_d.base    = wdata_i[DATA_W-1:IDX_W];
                    c_d.init_st = INIT_W2;
                end
                INIT_W2: c_d.init_st = INIT_W3;
                default: c_d.init_st = INIT_NONE;
            endcase
        end
        if (is_start) begin
            c_d.init_st = INIT_W1;
            c_d.level   = wdata_i[LEVEL_BIT];
            c_d.mask    = '0;
            c_d.isr     = '0;
            c_d.sel_isr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign rdata_o = a0_i ? DATA_W'(c_q.mask)
                   : (c_q.sel_isr ? DATA_W'(c_q.isr) : DATA_W'(irr));
    assign vector_o       = c_q.vec;
    assign vector_valid_o = c_q.vec_vld;

    // R2: start command always enters the first setup word
    p_start_enters_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_start |=> (c_q.init_st == INIT_W1));

    // R3: nothing unmasked pending means no interrupt
    p_mask_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((irr & ~c_q.mask) == '0) |-> !intr_o);

    // R7: a granted acknowledge adds exactly one in-service bit
    p_grant_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_i && intr_o && !is_eoi && !is_start)
        |=> ($countones(c_q.isr) == $past($countones(c_q.isr)) + 1));

    // R8: acknowledge with no winner returns line 7 code
    p_spurious_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_i && !intr_o) |=> (vector_valid_o && (vector_o[IDX_W-1:0] == {IDX_W{1'b1}})));

    // R8: spurious acknowledge leaves in-service untouched
    p_spurious_isr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_i && !intr_o && !is_eoi && !is_start) |=> $stable(c_q.isr));

    // R9: end-of-interrupt removes exactly one in-service bit
    p_eoi_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_eoi && isr_any && !inta_i)
        |=> ($countones(c_q.isr) == $past($countones(c_q.isr)) - 1));
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
    localparam int OP_NONE = 0;
    localparam int OP_CMD  = 1;
    localparam int OP_DAT  = 2;
    localparam int OP_ACK  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, wr = 1'b0, a0 = 1'b0, inta = 1'b0;
    logic [7:0] wdata = '0, irq = '0;
    logic [7:0] rdata, vector;
    logic       intr, vvld;

    int n_chk = 0;
    int n_fail = 0;

    // reference state
    logic [7:0] m_irr = '0, m_isr = '0, m_mask = '0, m_prev = '0;
    logic [4:0] m_base = '0;
    logic       m_level = 1'b0, m_sel = 1'b0;
    int         m_init = 0;

    always #10 clk = ~clk;

    prio_irq_ctrl uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cs_i           (cs),
        .wr_i           (wr),
        .a0_i           (a0),
        .wdata_i        (wdata),
        .rdata_o        (rdata),
        .irq_i          (irq),
        .inta_i         (inta),
        .intr_o         (intr),
        .vector_o       (vector),
        .vector_valid_o (vvld)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic exp_intr();
        int lp;
        int li;
        lp = lowest(m_irr & ~m_mask);
        li = lowest(m_isr);
        return (lp >= 0) && ((li < 0) || (lp < li));
    endfunction

    task automatic step(input logic [7:0] irq_v, input int op, input logic [7:0] d);
        logic [7:0] n_irr, n_isr, n_mask, exp_vec;
        logic [4:0] n_base;
        logic       n_level, n_sel, grant;
        int         n_init, lp, li;
        irq   = irq_v;
        cs    = (op == OP_CMD) || (op == OP_DAT);
        wr    = cs;
        a0    = (op == OP_DAT);
        wdata = d;
        inta  = (op == OP_ACK);
        lp    = lowest(m_irr & ~m_mask);
        li    = lowest(m_isr);
        grant = exp_intr() && (op == OP_ACK);
        for (int b = 0; b < 8; b++)
            n_irr[b] = m_level ? irq_v[b] : ((m_irr[b] | (irq_v[b] & ~m_prev[b])) & irq_v[b]);
        n_isr = m_isr; n_mask = m_mask; n_base = m_base;
        n_level = m_level; n_sel = m_sel; n_init = m_init;
        exp_vec = {m_base, 3'b111};
        if (grant) begin
            n_irr[lp] = 1'b0;
            n_isr[lp] = 1'b1;
            exp_vec = {m_base, 3'(lp)};
        end
        if (op == OP_CMD) begin
            if (d[4]) begin
                n_irr = '0; n_isr = '0; n_mask = '0; n_sel = 1'b0;
                n_level = d[3]; n_init = 1;
            end else if (d[3]) begin
                if (d[1]) n_sel = d[0];
            end else if (d[7:5] == 3'b001 && li >= 0) begin
                n_isr[li] = 1'b0;
            end
        end
        if (op == OP_DAT) begin
            case (m_init)
                0: n_mask = d;
                1: begin n_base = d[7:3]; n_init = 2; end
                2: n_init = 3;
                default: n_init = 0;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        cs = 1'b0; wr = 1'b0; a0 = 1'b0; inta = 1'b0;
        m_prev = irq_v; m_irr = n_irr; m_isr = n_isr; m_mask = n_mask;
        m_base = n_base; m_level = n_level; m_sel = n_sel; m_init = n_init;
        check("R6 interrupt output", {7'b0, intr}, {7'b0, exp_intr()});
        check("R7 vector valid", {7'b0, vvld}, {7'b0, (op == OP_ACK)});
        if (op == OP_ACK) check(grant ? "R7 vector" : "R8 spurious vector", vector, exp_vec);
    endtask

    task automatic rdchk(input string req);
        a0 = 1'b1; #1;
        check({req, " mask readback"}, rdata, m_mask);
        a0 = 1'b0; #1;
        check({req, " command readback"}, rdata, m_sel ? m_isr : m_irr);
    endtask

    task automatic rd_cmd(input string req, input logic [7:0] exp);
        a0 = 1'b0; #1;
        check(req, rdata, exp);
    endtask

    task automatic rd_mask(input string req, input logic [7:0] exp);
        a0 = 1'b1; #1;
        check(req, rdata, exp);
        a0 = 1'b0;
    endtask

    task automatic random_phase(input int n);
        logic [7:0] irqv;
        irqv = irq;
        for (int k = 0; k < n; k++) begin
            int r;
            r = $urandom_range(9);
            case (r)
                0, 1, 2, 3: begin
                    irqv = irqv ^ 8'(1 << $urandom_range(7));
                    step(irqv, OP_NONE, 8'h00);
                end
                4, 5: step(irqv, OP_ACK, 8'h00);
                6: step(irqv, OP_CMD, 8'h20);
                7: step(irqv, OP_DAT, 8'($urandom) & 8'($urandom));
                8: begin
                    step(irqv, OP_CMD, {7'b0000101, 1'($urandom)});
                    rdchk("R10 random");
                end
                default: rdchk("R3 random");
            endcase
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 intr after reset", {7'b0, intr}, 8'h00);
        check("R1 vector valid after reset", {7'b0, vvld}, 8'h00);
        rd_mask("R1 mask after reset", 8'h00);
        rd_cmd("R1 pending after reset", 8'h00);

        // R2 setup sequence, edge mode, base 0x20
        step(8'h00, OP_CMD, 8'h10);
        step(8'h00, OP_DAT, 8'h20);
        step(8'h00, OP_DAT, 8'hAA);
        step(8'h00, OP_DAT, 8'h55);
        rd_mask("R2 later setup words leave mask", 8'h00);
        step(8'h00, OP_DAT, 8'hFF);
        rd_mask("R3 mask write", 8'hFF);

        // R3 masked line
        step(8'h08, OP_NONE, 8'h00);
        check("R3 masked line quiet", {7'b0, intr}, 8'h00);
        step(8'h08, OP_DAT, 8'h00);
        check("R3 unmasked line raises", {7'b0, intr}, 8'h01);
        step(8'h08, OP_ACK, 8'h00);
        check("R7 line 3 vector", vector, 8'h23);

        // R10 readback selection persists
        step(8'h08, OP_CMD, 8'h0B);
        rd_cmd("R10 in-service readback", 8'h08);
        step(8'h08, OP_CMD, 8'h08);
        rd_cmd("R10 selection kept", 8'h08);

        // R6 nesting
        step(8'h28, OP_NONE, 8'h00);
        check("R6 blocked by in-service", {7'b0, intr}, 8'h00);
        rd_cmd("R10 selection persists across reads", 8'h08);
        step(8'h2A, OP_NONE, 8'h00);
        check("R6 higher line preempts", {7'b0, intr}, 8'h01);
        step(8'h2A, OP_ACK, 8'h00);
        check("R7 line 1 vector", vector, 8'h21);
        step(8'h2A, OP_CMD, 8'h60);
        rd_cmd("R9 other code ignored", 8'h0A);
        step(8'h2A, OP_CMD, 8'h20);
        rd_cmd("R9 clears lowest in-service", 8'h08);
        step(8'h2A, OP_CMD, 8'h20);
        check("R6 line 5 unblocked", {7'b0, intr}, 8'h01);
        step(8'h2A, OP_ACK, 8'h00);
        check("R7 line 5 vector", vector, 8'h25);
        step(8'h2A, OP_CMD, 8'h20);
        check("R4 held line no re-request", {7'b0, intr}, 8'h00);

        // R8 request vanishes before acknowledge
        step(8'h6A, OP_NONE, 8'h00);
        check("R4 line 6 edge", {7'b0, intr}, 8'h01);
        step(8'h2A, OP_NONE, 8'h00);
        check("R4 dropped line clears", {7'b0, intr}, 8'h00);
        step(8'h2A, OP_ACK, 8'h00);
        check("R8 spurious code", vector, 8'h27);
        rd_cmd("R8 in-service unchanged", 8'h00);

        // R3 higher-priority line masked, lower served
        step(8'h2A, OP_DAT, 8'h04);
        step(8'h3E, OP_NONE, 8'h00);
        step(8'h3E, OP_ACK, 8'h00);
        check("R3 masked line 2 skipped", vector, 8'h24);
        step(8'h3E, OP_CMD, 8'h20);
        step(8'h3E, OP_DAT, 8'h00);
        step(8'h3E, OP_ACK, 8'h00);
        check("R3 line 2 after unmask", vector, 8'h22);
        step(8'h3E, OP_CMD, 8'h20);

        // R5 level mode, base 0x40
        step(8'h00, OP_CMD, 8'h18);
        step(8'h00, OP_DAT, 8'h40);
        step(8'h00, OP_DAT, 8'h00);
        step(8'h00, OP_DAT, 8'h00);
        step(8'h01, OP_NONE, 8'h00);
        step(8'h01, OP_ACK, 8'h00);
        check("R7 level line 0 vector", vector, 8'h40);
        step(8'h01, OP_CMD, 8'h20);
        check("R5 held level re-requests", {7'b0, intr}, 8'h01);
        step(8'h01, OP_ACK, 8'h00);
        step(8'h01, OP_CMD, 8'h20);
        step(8'h00, OP_NONE, 8'h00);
        check("R5 level low quiet", {7'b0, intr}, 8'h00);
        rd_cmd("R5 pending follows level", 8'h00);

        random_phase(400);

        // back to edge mode, base 0xC8
        step(irq, OP_CMD, 8'h10);
        step(irq, OP_DAT, 8'hC8);
        step(irq, OP_DAT, 8'h00);
        step(irq, OP_DAT, 8'h00);
        rdchk("R2 after re-setup");
        random_phase(400);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule